// File: doc/BRIEF.md
# Twice-High Pulse Detector

This block watches a single-bit level input and produces a one-clock pulse the second time that input is seen high, provided it was first seen high and then low. After the pulse the detector refuses to count again until the input has dropped low, so a level that stays high after the second assertion cannot produce a further pulse. It is a Moore machine: the pulse is decoded from the state alone and never follows the input combinationally.

The state register moves through a fixed sequence of three-bit codes in which every step flips exactly one bit, the return to idle included. A pass-through state sits between the pulse state and the final wait state so that this holds. The two codes outside the sequence lead straight back to idle. A parameter selects whether the pulse is decoded directly from the state or retimed through one extra flop. The current state code is brought out so that the sequence can be observed at the block's edge. The input is sampled on the rising clock edge and is expected to be synchronous and clean already.

Top module: `twice_high_pulse`

## Requirements
- R1: While `rst_i` is high at a rising clock edge, the state code becomes 000 on that edge, and `pulse_o` is 0 in the following cycle.
- R2: In code 000 (idle), `d_i` = 1 moves the code to 100; `d_i` = 0 keeps it at 000.
- R3: In code 100 (first high seen), `d_i` = 0 moves the code to 110; `d_i` = 1 keeps it at 100.
- R4: In code 110 (first low seen), `d_i` = 1 moves the code to 111; `d_i` = 0 keeps it at 110.
- R5: With `OUT_REG` = 0, `pulse_o` is 1 exactly while the code is 111. Code 111 lasts one clock whatever `d_i` is, so each pulse is one clock wide.
- R6: Code 111 is followed by 011, and 011 is followed by 001, each after one clock and regardless of `d_i`.
- R7: In code 001 (wait for low), `d_i` = 0 moves the code to 000; `d_i` = 1 keeps it at 001.
- R8: Every change of the state code between reachable codes flips exactly one bit.
- R9: Codes 010 and 101 are never reached from reset. If the register ever holds one of them, the next code is 000, and `pulse_o` is 0 while it is held.
- R10: With `OUT_REG` = 1, `pulse_o` equals the R5 pulse delayed by one clock, and it is 0 in the cycle after a reset edge.

Parameter `OUT_REG` (0 or 1, default 0) selects between the direct decode and the retimed output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all state changes on the rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| d_i | input | 1 | Monitored level, synchronous to `clk_i` |
| pulse_o | output | 1 | One-clock pulse on the second assertion of `d_i` |
| state_o | output | 3 | Current state code |

## Verification
The transition assertions assume that `d_i` is already synchronous to `clk_i`, so the value seen at each rising edge is the value that decides the step. The stimulus changes `d_i` only on falling edges. The recovery property for unused codes assumes that such a code can only come from upset, never from stimulus. The stimulus therefore reaches codes only through the input, and the bench checks that neither unused code appears. Input sequences include levels held for many cycles, single-cycle toggles, `d_i` held high through the pulse and pass-through states, and a reset in the middle of a sequence.

// File: rtl/thp_pkg.sv
package thp_pkg;

   localparam int unsigned STATE_W = 3;

   typedef enum logic [STATE_W-1:0] {
      ST_IDLE   = 3'b000,
      ST_FIRST  = 3'b100,
      ST_GAP    = 3'b110,
      ST_FIRE   = 3'b111,
      ST_BRIDGE = 3'b011,
      ST_DRAIN  = 3'b001
   } st_e;

   function automatic logic code_legal(input logic [STATE_W-1:0] c);
      return !((c == 3'b010) || (c == 3'b101));
   endfunction

endpackage

// File: rtl/thp_next.sv
module thp_next
   import thp_pkg::*;
#(
   parameter int unsigned SW = STATE_W
)(
   input  logic [SW-1:0] cur_i,
   input  logic          d_i,
   output logic [SW-1:0] nxt_o
);

   if (SW != STATE_W) begin : g_bad_width
      $error("thp_next: SW must equal the package state width");
   end

   always_comb begin
      case (cur_i)
         ST_IDLE:   nxt_o = d_i  ? ST_FIRST  : ST_IDLE;
         ST_FIRST:  nxt_o = !d_i ? ST_GAP    : ST_FIRST;
         ST_GAP:    nxt_o = d_i  ? ST_FIRE   : ST_GAP;
         ST_FIRE:   nxt_o = ST_BRIDGE;
         ST_BRIDGE: nxt_o = ST_DRAIN;
         ST_DRAIN:  nxt_o = !d_i ? ST_IDLE   : ST_DRAIN;
         default:   nxt_o = ST_IDLE;
      endcase
   end

endmodule

// File: rtl/thp_state_reg.sv
module thp_state_reg
   import thp_pkg::*;
#(
   parameter int unsigned SW = STATE_W
)(
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic [SW-1:0] nxt_i,
   output logic [SW-1:0] cur_o
);

   if (SW != STATE_W) begin : g_bad_width
      $error("thp_state_reg: SW must equal the package state width");
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) cur_o <= ST_IDLE;
      else       cur_o <= nxt_i;
   end

   // R1
   reset_idle_chk: assert property (@(posedge clk_i) rst_i |=> (cur_o == ST_IDLE));

   // R8
   unit_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      code_legal(cur_o) |=> ($stable(cur_o) || ($countones(cur_o ^ $past(cur_o)) == 1)));

   // R9
   unused_recover_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !code_legal(cur_o) |=> (cur_o == ST_IDLE));

endmodule

// File: rtl/thp_out.sv
module thp_out
   import thp_pkg::*;
#(
   parameter int unsigned SW      = STATE_W,
   parameter bit          OUT_REG = 1'b0
)(
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic [SW-1:0] cur_i,
   output logic          pulse_o
);

   if (SW != STATE_W) begin : g_bad_width
      $error("thp_out: SW must equal the package state width");
   end

   logic fire_w;
   assign fire_w = (cur_i == ST_FIRE);

   if (OUT_REG) begin : g_retimed
      always_ff @(posedge clk_i) begin
         if (rst_i) pulse_o <= 1'b0;
         else       pulse_o <= fire_w;
      end
      // R10
      retime_chk: assert property (@(posedge clk_i) disable iff (rst_i)
         (cur_i == ST_FIRE) |=> pulse_o);
   end else begin : g_direct
      assign pulse_o = fire_w;
      // R9
      unused_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
         !code_legal(cur_i) |-> !pulse_o);
   end

   // R5
   one_clock_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(pulse_o) |=> !pulse_o);

endmodule

// File: rtl/twice_high_pulse.sv
module twice_high_pulse
   import thp_pkg::*;
#(
   parameter bit OUT_REG = 1'b0
)(
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic               d_i,
   output logic               pulse_o,
   output logic [STATE_W-1:0] state_o
);

   localparam int unsigned SW = STATE_W;

   if (SW != 3) begin : g_bad_encoding
      $error("twice_high_pulse: the unit-distance encoding needs three bits");
   end

   logic [SW-1:0] nxt_w;
   logic [SW-1:0] cur_w;

   thp_next #(.SW(SW)) i_next (
      .cur_i (cur_w),
      .d_i   (d_i),
      .nxt_o (nxt_w)
   );

   thp_state_reg #(.SW(SW)) i_reg (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .nxt_i (nxt_w),
      .cur_o (cur_w)
   );

   thp_out #(.SW(SW), .OUT_REG(OUT_REG)) i_out (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .cur_i   (cur_w),
      .pulse_o (pulse_o)
   );

   assign state_o = cur_w;

   // R2
   idle_arm_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_o == ST_IDLE && d_i) |=> (state_o == ST_FIRST));
   // R2
   idle_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_o == ST_IDLE && !d_i) |=> (state_o == ST_IDLE));
   // R3
   first_low_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_o == ST_FIRST && !d_i) |=> (state_o == ST_GAP));
   // R3
   first_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_o == ST_FIRST && d_i) |=> (state_o == ST_FIRST));
   // R4
   gap_high_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_o == ST_GAP && d_i) |=> (state_o == ST_FIRE));
   // R4
   gap_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_o == ST_GAP && !d_i) |=> (state_o == ST_GAP));
   // R6
   fire_leave_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_o == ST_FIRE) |=> (state_o == ST_BRIDGE));
   // R6
   bridge_leave_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_o == ST_BRIDGE) |=> (state_o == ST_DRAIN));
   // R7
   drain_exit_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_o == ST_DRAIN && !d_i) |=> (state_o == ST_IDLE));
   // R7
   drain_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_o == ST_DRAIN && d_i) |=> (state_o == ST_DRAIN));

endmodule

// File: tb/test_twice_high_pulse.sv
module test_twice_high_pulse;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       d   = 1'b0;
   logic       p_dir;
   logic       p_reg;
   logic [2:0] code_dir;
   logic [2:0] code_reg;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   twice_high_pulse #(.OUT_REG(1'b0)) i_twice_high_pulse (
      .clk_i(clk), .rst_i(rst), .d_i(d), .pulse_o(p_dir), .state_o(code_dir));

   twice_high_pulse #(.OUT_REG(1'b1)) i_twice_high_pulse_reg (
      .clk_i(clk), .rst_i(rst), .d_i(d), .pulse_o(p_reg), .state_o(code_reg));

   // Reference model: phase 0 idle, 1 first high, 2 first low,
   // 3 pulse, 4 pass-through, 5 wait for low.
   int  ph      = 0;
   int  prev_ph = 0;
   bit  exp_preg = 1'b0;
   bit  was_rst  = 1'b1;
   logic [2:0] last_code = 3'b000;
   bit  have_last = 1'b0;

   function automatic logic [2:0] code_of(input int k);
      case (k)
         0: return 3'b000;
         1: return 3'b100;
         2: return 3'b110;
         3: return 3'b111;
         4: return 3'b011;
         default: return 3'b001;
      endcase
   endfunction

   function automatic string tag_of(input int from, input bit r);
      if (r) return "R1";
      case (from)
         0: return "R2";
         1: return "R3";
         2: return "R4";
         3: return "R6";
         4: return "R6";
         default: return "R7";
      endcase
   endfunction

   always @(posedge clk) begin
      prev_ph = ph;
      was_rst = rst;
      if (rst) begin
         ph = 0;
         exp_preg = 1'b0;
      end else begin
         exp_preg = (ph == 3);
         case (ph)
            0: ph = d ? 1 : 0;
            1: ph = d ? 1 : 2;
            2: ph = d ? 3 : 2;
            3: ph = 4;
            4: ph = 5;
            default: ph = d ? 5 : 0;
         endcase
      end
   end

   always @(negedge clk) begin
      if (!done && $time > 10) begin
         checks++;
         if (code_dir !== code_of(ph) || code_reg !== code_of(ph)) begin
            errors++;
            $display("FAIL %s code actual %b/%b expected %b", tag_of(prev_ph, was_rst),
                     code_dir, code_reg, code_of(ph));
         end
         checks++;
         if (p_dir !== (ph == 3)) begin
            errors++;
            $display("FAIL %s pulse actual %b expected %b", was_rst ? "R1" : "R5",
                     p_dir, (ph == 3));
         end
         checks++;
         if (p_reg !== exp_preg) begin
            errors++;
            $display("FAIL R10 retimed pulse actual %b expected %b", p_reg, exp_preg);
         end
         checks++;
         if (code_dir === 3'b010 || code_dir === 3'b101) begin
            errors++;
            $display("FAIL R9 unused code actual %b expected legal code", code_dir);
         end
         if (have_last && !was_rst && code_dir !== last_code) begin
            checks++;
            if ($countones(code_dir ^ last_code) != 1) begin
               errors++;
               $display("FAIL R8 step actual %b->%b expected one bit flip",
                        last_code, code_dir);
            end
         end
         last_code = code_dir;
         have_last = 1'b1;
      end
   end

   task automatic hold(input bit v, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         d = v;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // slow full sequence
      hold(1'b0, 3); hold(1'b1, 4); hold(1'b0, 4); hold(1'b1, 6); hold(1'b0, 3);
      // fast toggling every clock
      for (int i = 0; i < 24; i++) hold(i[0], 1);
      // d held high through pulse and pass-through, long drain
      hold(1'b1, 1); hold(1'b0, 1); hold(1'b1, 12); hold(1'b0, 2);
      // reset in the middle of a sequence (R1)
      hold(1'b1, 2); hold(1'b0, 2);
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      hold(1'b1, 2); hold(1'b0, 2); hold(1'b1, 2); hold(1'b0, 3);
      // high-low-high patterns of varying width
      for (int w = 1; w < 5; w++) begin
         hold(1'b1, w); hold(1'b0, w + 1); hold(1'b1, 5 - w); hold(1'b0, 2);
      end
      hold(1'b0, 4);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual hung expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule